// File: doc/BRIEF.md
# Zig-Zag Scatter Write Address Generator

This block sits in front of a 64-entry buffer that collects one 8x8 block of samples. The samples arrive one per accepted cycle in raster order: row 0 from left to right, then row 1, and so on. For each sample the block emits a write address equal to that sample's position in the zig-zag scan. After a whole block has been written this way, a plain incrementing read of addresses 0 through 63 returns the samples already in zig-zag order. The reordering is done on the write side, so the read side needs no address logic.

The zig-zag scan starts at the top-left corner and first heads up and to the right. On a diagonal heading up-right, it turns at the last column by moving down one row, or else at row 0 by moving right one column. On a diagonal heading down-left, it turns at the last row by moving right one column, or else at column 0 by moving down one row.

The address is not read from a table. Row and column counters track the incoming sample, and the scan rank is computed from them. That rank is the number of cells on all earlier anti-diagonals plus an offset within the current diagonal, and the direction of each diagonal follows from its parity.

Top module: `zz_write_addr`

## Requirements
- R1: After reset, `wr_en` and `done` are low, and the first sample accepted after reset is treated as raster index 0, so its write address is 0.
- R2: `wr_en` is high in exactly the cycle after a cycle with `vld_in` high, and low in the cycle after a cycle with `vld_in` low.
- R3: For the sample with raster index k, where row = k/8 and column = k mod 8, `wr_addr` equals the step number (counting from 0) at which the zig-zag scan visits that row and column.
- R4: Cycles with `vld_in` low do not advance the raster index, so gaps between samples leave the address sequence unchanged.
- R5: `done` is high for exactly one cycle, together with `wr_en`, when the address for raster index 63 is presented, and that address is 63.
- R6: After the 64th accepted sample, the raster index returns to 0, so the next block repeats the same address sequence.
- R7: A high `start` abandons any partial block and resets the raster index to 0. If `vld_in` is also high in that cycle, that sample is taken as raster index 0.
- R8: Over one block, the 64 write addresses are all distinct, so every buffer entry is written exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Restart strobe; resets the raster index to 0 |
| vld_in | input | 1 | A sample is present this cycle |
| wr_addr | output | 6 | Buffer write address (zig-zag rank), registered |
| wr_en | output | 1 | Qualifies `wr_addr` |
| done | output | 1 | Marks the write of the last sample of a block |

## Verification
Only one register stage separates the position counters from the ports. A wrong counter value therefore shows up as a wrong `wr_addr` on the very next accepted sample, and a skipped or repeated position shows up as a duplicate address within the same block. A counter that fails to wrap, or wraps early, moves `done` away from the 64th write, or makes it carry an address other than 63. This is visible within one block and again at the start of the next one. The tests use contiguous input, gapped input and back-to-back blocks, and restart in the middle of a block. That exposes stalls, wraps and restart priority at the ports.

// File: rtl/zz_pkg.sv
package zz_pkg;

    localparam int ZZ_N    = 8;
    localparam int ZZ_CW   = $clog2(ZZ_N);
    localparam int ZZ_AW   = 2 * ZZ_CW;
    localparam int ZZ_LAST = ZZ_N * ZZ_N - 1;

    typedef logic [ZZ_CW-1:0] coord_t;
    typedef logic [ZZ_AW-1:0] addr_t;

    typedef struct packed {
        coord_t row;
        coord_t col;
    } pos_t;

    typedef struct packed {
        logic  wen;
        logic  last;
        addr_t addr;
    } wr_t;

    // cells lying on anti-diagonals strictly before diagonal d
    function automatic int diag_base(input int d);
        if (d < ZZ_N)
            return d * (d + 1) / 2;
        else
            return ZZ_N * ZZ_N - (2 * ZZ_N - 1 - d) * (2 * ZZ_N - d) / 2;
    endfunction

    // position of (row, col) along the zig-zag path
    function automatic addr_t scan_rank(input pos_t p);
        int r, c, d, lo, off;
        r  = int'(p.row);
        c  = int'(p.col);
        d  = r + c;
        lo = (d < ZZ_N) ? 0 : d - (ZZ_N - 1);
        // even diagonals run up-right (ordered by column), odd run down-left (by row)
        off = (d % 2 == 0) ? (c - lo) : (r - lo);
        return addr_t'(diag_base(d) + off);
    endfunction

endpackage

// File: rtl/zz_pos_counter.sv
module zz_pos_counter
    import zz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic adv,
    output pos_t cur,
    output logic last
);

    localparam coord_t MAXC = coord_t'(ZZ_N - 1);

    pos_t pos_q;

    always_comb begin
        cur  = start ? '0 : pos_q;
        last = (cur.row == MAXC) && (cur.col == MAXC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (adv) begin
            if (cur.col == MAXC) begin
                pos_q.col <= '0;
                pos_q.row <= last ? '0 : cur.row + 1'b1;
            end else begin
                pos_q.col <= cur.col + 1'b1;
                pos_q.row <= cur.row;
            end
        end else if (start) begin
            pos_q <= '0;
        end
    end

    p_col_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && cur.col == MAXC) |=> (pos_q.col == '0));

    p_block_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && last) |=> (pos_q == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!adv && !start) |=> $stable(pos_q));

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !adv) |=> (pos_q == '0));

endmodule

// File: rtl/zz_rank_calc.sv
module zz_rank_calc
    import zz_pkg::*;
(
    input  pos_t  pos,
    output addr_t rank
);

    always_comb begin
        rank = scan_rank(pos);
    end

endmodule

// File: rtl/zz_write_addr.sv
module zz_write_addr
    import zz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             vld_in,
    output logic [ZZ_AW-1:0] wr_addr,
    output logic             wr_en,
    output logic             done
);

    pos_t  cur_pos;
    logic  cur_last;
    addr_t cur_rank;
    wr_t   out_q;

    zz_pos_counter i_cnt (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .adv   (vld_in),
        .cur   (cur_pos),
        .last  (cur_last)
    );

    zz_rank_calc i_rank (
        .pos  (cur_pos),
        .rank (cur_rank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.wen  <= vld_in;
            out_q.last <= vld_in && cur_last;
            out_q.addr <= cur_rank;
        end
    end

    assign wr_addr = out_q.addr;
    assign wr_en   = out_q.wen;
    assign done    = out_q.last;

    p_wen_follows_r2: assert property (@(posedge clk) disable iff (rst)
        vld_in |=> wr_en);

    p_wen_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> !wr_en);

    p_done_addr_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_en && wr_addr == addr_t'(ZZ_LAST)));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/test_zz_write_addr.sv
module test_zz_write_addr;

    localparam int CLK_PERIOD = 10;
    localparam int NN = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       vld_in = 1'b0;
    logic [5:0] wr_addr;
    logic       wr_en;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;
    int inv_ref [NN];
    bit finished = 1'b0;

    zz_write_addr i_zz_write_addr (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .vld_in  (vld_in),
        .wr_addr (wr_addr),
        .wr_en   (wr_en),
        .done    (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Build the expected ranks by walking the scan path with its turning rules.
    task automatic build_ref();
        int r = 0, c = 0;
        bit up = 1'b1;
        for (int i = 0; i < NN; i++) begin
            inv_ref[r*8 + c] = i;
            if (up) begin
                if (c == 7)      begin r++; up = 1'b0; end
                else if (r == 0) begin c++; up = 1'b0; end
                else             begin c++; r--; end
            end else begin
                if (r == 7)      begin c++; up = 1'b1; end
                else if (c == 0) begin r++; up = 1'b1; end
                else             begin c--; r++; end
            end
        end
    endtask

    // Called at a falling edge: drive, then sample at the next falling edge.
    task automatic cyc(input logic v, input logic s);
        vld_in = v;
        start  = s;
        @(negedge clk);
        vld_in = 1'b0;
        start  = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(wr_en == 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst = 1'b0;
        cyc(1'b0, 1'b0);
        check(wr_en == 1'b0, "R2 idle after reset", int'(wr_en), 0);
    endtask

    // gap: 0 contiguous, otherwise an idle cycle after every sample whose index mod gap == gap-1
    task automatic t_block(input int gap, input string tag);
        bit [NN-1:0] seen = '0;
        int dups = 0;
        for (int k = 0; k < NN; k++) begin
            cyc(1'b1, 1'b0);
            check(wr_en == 1'b1, {tag, " R2 wr_en"}, int'(wr_en), 1);
            check(int'(wr_addr) == inv_ref[k], {tag, " R3 address"}, int'(wr_addr), inv_ref[k]);
            check(done == (k == NN-1), {tag, " R5 done"}, int'(done), int'(k == NN-1));
            if (seen[wr_addr]) dups++;
            seen[wr_addr] = 1'b1;
            if (gap != 0 && (k % gap) == gap-1) begin
                cyc(1'b0, 1'b0);
                check(wr_en == 1'b0 && done == 1'b0, {tag, " R4 gap quiet"}, int'(wr_en), 0);
            end
        end
        check(dups == 0 && seen == '1, {tag, " R8 permutation"}, dups, 0);
        cyc(1'b0, 1'b0);
        check(done == 1'b0, {tag, " R5 single pulse"}, int'(done), 0);
    endtask

    task automatic t_restart();
        for (int k = 0; k < 13; k++) cyc(1'b1, 1'b0);
        // start alone clears the index
        cyc(1'b0, 1'b1);
        check(wr_en == 1'b0, "R7 start alone no write", int'(wr_en), 0);
        cyc(1'b1, 1'b0);
        check(int'(wr_addr) == 0, "R7 restart index 0", int'(wr_addr), 0);
        cyc(1'b1, 1'b0);
        check(int'(wr_addr) == inv_ref[1], "R7 restart index 1", int'(wr_addr), inv_ref[1]);
        for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0);
        // start together with a sample: that sample is index 0
        cyc(1'b1, 1'b1);
        check(wr_en == 1'b1 && int'(wr_addr) == 0, "R7 start with sample", int'(wr_addr), 0);
        for (int k = 1; k < NN; k++) begin
            cyc(1'b1, 1'b0);
            check(int'(wr_addr) == inv_ref[k], "R7 block after start", int'(wr_addr), inv_ref[k]);
        end
        check(done == 1'b1 && int'(wr_addr) == 63, "R5 done after restart", int'(wr_addr), 63);
        cyc(1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        build_ref();
        @(negedge clk);
        t_reset();
        t_block(0, "contiguous");      // R1 first address is 0, R3
        t_block(0, "second block");    // R6 wrap to a new block
        t_block(3, "gapped");          // R4
        t_block(7, "sparse");          // R4
        t_restart();                   // R7
        t_block(0, "final");           // R6
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule